// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is the translation engine of a memory management unit. For every access it takes a 32-bit virtual address and an access type (load, store or instruction fetch), reads a directory entry and then a leaf entry from memory, and returns a physical address built from the leaf's page frame number and the untouched 12-bit page offset. The walk starts from a frame number held in a base register, which software rewrites when it switches to another process.

Each entry carries a present flag and, at the leaf, read, write and execute permissions plus a dirty flag. A missing entry at either level ends the walk with a not-present fault. A leaf that lacks the right needed by the access type ends it with a protection fault. Every fault reports the faulting virtual address. A store that hits a clean page writes the leaf back with its dirty flag set before the translation is reported. Only one walk is in flight at a time. Memory is reached through a single request/acknowledge port that carries both entry reads and the dirty write-back.

The controller is a state machine with six states. `S_IDLE` accepts a request (goes to `S_DIR_RD`). `S_DIR_RD` reads the directory entry and goes to `S_LEAF_RD` if present, or to `S_FAULT` if not. `S_LEAF_RD` reads the leaf entry and goes to `S_FAULT` on a missing entry or a denied right. It goes to `S_LEAF_WB` for a store to a clean page, and to `S_FINISH` otherwise. `S_LEAF_WB` writes the leaf back and goes to `S_FINISH`. `S_FINISH` and `S_FAULT` each last one cycle and return to `S_IDLE`.

Top module: `xlate_walker`

## Requirements
- R1: After reset, req_ready is 1, and mem_req, done and flt are 0. The base register holds 0.
- R2: Entry layout: bit 0 present, bit 1 read, bit 2 write, bit 3 execute, bit 4 dirty, bits 28:12 frame number. The directory read goes to address {base, vaddr[31:22], 2'b00}, and only the present bit and frame number of a directory entry matter.
- R3: The leaf read goes to address {directory frame number, vaddr[21:12], 2'b00}.
- R4: A successful walk raises done for exactly one cycle with done_paddr = {leaf frame number, vaddr[11:0]}.
- R5: A directory entry with present = 0 ends the walk with flt and cause 1 (not present), after exactly one memory read.
- R6: A leaf entry with present = 0 ends the walk with flt and cause 1.
- R7: The access type (req_kind) selects the right that is needed: 0 load needs read, 1 store needs write, 2 fetch needs execute, and 3 is treated as a load. A missing right ends the walk with flt and cause 2 (protection).
- R8: A store to a present, writable leaf with dirty = 0 writes the leaf back to its own address with bit 4 set and every other bit unchanged, before done. A store to a dirty leaf, and every load or fetch, issues no write.
- R9: On a fault, flt_vaddr equals the virtual address of the walk. done and flt are never high in the same cycle.
- R10: A base write takes effect for walks accepted after it. A write during a walk does not change the walk in progress.
- R11: mem_req, mem_we and mem_addr hold steady until mem_ack. req_ready is high only between walks, and never while mem_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Write strobe for the base register |
| base_ppn | input | 17 | New directory frame number |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is an entry write-back |
| mem_addr | output | 29 | Physical byte address of the entry |
| mem_wdata | output | 32 | Entry value written back |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Entry read, valid with mem_ack |
| done | output | 1 | One-cycle translation complete pulse |
| done_paddr | output | 29 | Physical address, valid with done |
| flt | output | 1 | One-cycle fault pulse |
| flt_cause | output | 2 | 1 not present, 2 protection |
| flt_vaddr | output | 32 | Faulting virtual address |

## Verification
Several properties are checked on every cycle by the assertions. The memory request must stay steady until it is acknowledged, and the walker never accepts work while it has memory traffic. done and flt are exclusive, a fault always carries a legal cause and the walk's own address, and the page offset passes through to the result. Every write-back sets both present and dirty and targets the leaf that was just read. The bench scenarios are needed for the rest: the actual frame numbers, the choice between not-present and protection for each access type, the single read after a directory miss, the write-back being skipped on dirty pages, and the base register's switch timing across a walk in flight.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Flag positions inside a table entry (leaf and directory share them)
    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_D = 4;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_NOTPRESENT = 2'd1,
        CAUSE_PROT       = 2'd2
    } cause_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_LEAF_RD,
        S_LEAF_WB,
        S_FINISH,
        S_FAULT
    } wstate_e;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
    parameter int          W       = 17,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic can_r,
    input  logic can_w,
    input  logic can_x,
    input  acc_e kind,
    output logic allow
);

    always_comb begin
        unique case (kind)
            ACC_STORE: allow = can_w;
            ACC_FETCH: allow = can_x;
            default:   allow = can_r;   // load and the spare code
        endcase
    end

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import ptw_pkg::*;
#(
    parameter  int VA_W  = 32,
    parameter  int IDX_W = 10,
    parameter  int PPN_W = 17,
    parameter  int ENT_W = 32,
    localparam int OFF_W = VA_W - 2 * IDX_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic [PPN_W-1:0] base_ppn,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [ENT_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             done,
    output logic [PA_W-1:0]  done_paddr,
    output logic             flt,
    output logic [1:0]       flt_cause,
    output logic [VA_W-1:0]  flt_vaddr
);

    localparam int PAD_W = OFF_W - IDX_W;   // zero bits above a scaled index

    // ---------------------------------------------------------------
    // State and walk registers
    // ---------------------------------------------------------------
    wstate_e          state_q, state_d;
    logic [VA_W-1:0]  va_q;
    acc_e             kind_q;
    logic [PPN_W-1:0] walk_base_q;
    logic [PPN_W-1:0] tbl_ppn_q;
    logic [PPN_W-1:0] leaf_ppn_q;
    logic [ENT_W-1:0] wb_q;
    cause_e           cause_q;
    logic [PPN_W-1:0] base_q;

    // ---------------------------------------------------------------
    // Address slicing and entry decode
    // ---------------------------------------------------------------
    logic [IDX_W-1:0] dir_idx, leaf_idx;
    logic [OFF_W-1:0] page_off;
    logic [PA_W-1:0]  dir_addr, leaf_addr;
    logic             ent_v, ent_d, perm_ok, need_wb, accept;
    logic [PPN_W-1:0] ent_ppn;

    assign dir_idx  = va_q[VA_W-1 -: IDX_W];
    assign leaf_idx = va_q[OFF_W +: IDX_W];
    assign page_off = va_q[OFF_W-1:0];

    assign dir_addr  = {walk_base_q, ({{PAD_W{1'b0}}, dir_idx}  << 2)};
    assign leaf_addr = {tbl_ppn_q,   ({{PAD_W{1'b0}}, leaf_idx} << 2)};

    assign ent_v   = mem_rdata[BIT_V];
    assign ent_d   = mem_rdata[BIT_D];
    assign ent_ppn = mem_rdata[OFF_W +: PPN_W];
    assign need_wb = (kind_q == ACC_STORE) && !ent_d;
    assign accept  = (state_q == S_IDLE) && req_valid;

    ptw_base_reg #(
        .W       (PPN_W),
        .RST_VAL ('0)
    ) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (base_we),
        .wdata (base_ppn),
        .q     (base_q)
    );

    ptw_perm_check u_perm (
        .can_r (mem_rdata[BIT_R]),
        .can_w (mem_rdata[BIT_W]),
        .can_x (mem_rdata[BIT_X]),
        .kind  (kind_q),
        .allow (perm_ok)
    );

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = S_DIR_RD;
            end
            S_DIR_RD: begin
                if (mem_ack) state_d = ent_v ? S_LEAF_RD : S_FAULT;
            end
            S_LEAF_RD: begin
                if (mem_ack) begin
                    if (!ent_v || !perm_ok) state_d = S_FAULT;
                    else if (need_wb)       state_d = S_LEAF_WB;
                    else                    state_d = S_FINISH;
                end
            end
            S_LEAF_WB: begin
                if (mem_ack) state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
            S_FAULT:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Walk datapath
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            kind_q      <= ACC_LOAD;
            walk_base_q <= '0;
            tbl_ppn_q   <= '0;
            leaf_ppn_q  <= '0;
            wb_q        <= '0;
            cause_q     <= CAUSE_NONE;
        end else begin
            if (accept) begin
                va_q        <= req_vaddr;
                kind_q      <= acc_e'(req_kind);
                walk_base_q <= base_q;           // snapshot: later writes wait
                cause_q     <= CAUSE_NONE;
            end
            if (state_q == S_DIR_RD && mem_ack) begin
                tbl_ppn_q <= ent_ppn;
                if (!ent_v) cause_q <= CAUSE_NOTPRESENT;
            end
            if (state_q == S_LEAF_RD && mem_ack) begin
                leaf_ppn_q <= ent_ppn;
                wb_q       <= mem_rdata | (ENT_W'(1) << BIT_D);
                if (!ent_v)        cause_q <= CAUSE_NOTPRESENT;
                else if (!perm_ok) cause_q <= CAUSE_PROT;
            end
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = dir_addr;
        mem_wdata  = wb_q;
        done       = 1'b0;
        flt        = 1'b0;
        unique case (state_q)
            S_IDLE:    req_ready = 1'b1;
            S_DIR_RD:  mem_req = 1'b1;
            S_LEAF_RD: begin
                mem_req  = 1'b1;
                mem_addr = leaf_addr;
            end
            S_LEAF_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = leaf_addr;
            end
            S_FINISH:  done = 1'b1;
            S_FAULT:   flt  = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    assign done_paddr = {leaf_ppn_q, page_off};
    assign flt_cause  = cause_q;
    assign flt_vaddr  = va_q;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PA_W  = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_ack,
    input logic             wb_v,
    input logic             wb_d,
    input logic             done,
    input logic [OFF_W-1:0] done_off,
    input logic             flt,
    input logic [1:0]       flt_cause,
    input logic [VA_W-1:0]  flt_vaddr
);

    logic [VA_W-1:0] seen_va;
    logic [PA_W-1:0] last_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_va <= '0;
            last_rd <= '0;
        end else begin
            if (req_valid && req_ready)         seen_va <= req_vaddr;
            if (mem_req && !mem_we && mem_ack)  last_rd <= mem_addr;
        end
    end

    AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);                                           // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
    AST_DONE_FLT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && flt));                                                   // R9
    AST_FLT_VADDR: assert property (@(posedge clk) disable iff (!rst_n)
        flt |-> (flt_vaddr == seen_va));                                   // R9
    AST_FLT_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        flt |-> (flt_cause == 2'd1 || flt_cause == 2'd2));                 // R7
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_off == seen_va[OFF_W-1:0]));                        // R4
    AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (wb_v && wb_d));                           // R8
    AST_WB_SAME_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == last_rd));                    // R8

endmodule

bind xlate_walker ptw_checker #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .wb_v      (mem_wdata[0]),
    .wb_d      (mem_wdata[4]),
    .done      (done),
    .done_off  (done_paddr[OFF_W-1:0]),
    .flt       (flt),
    .flt_cause (flt_cause),
    .flt_vaddr (flt_vaddr)
);

// File: tb/tb_xlate_walker.sv
`timescale 1ns/1ps
module tb_xlate_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_we;
    logic [16:0] base_ppn;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        mem_req, mem_we, mem_ack;
    logic [28:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        done, flt;
    logic [28:0] done_paddr;
    logic [1:0]  flt_cause;
    logic [31:0] flt_vaddr;

    always #2 clk = ~clk;   // 250 MHz

    xlate_walker dut (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_ppn(base_ppn),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .done_paddr(done_paddr),
        .flt(flt), .flt_cause(flt_cause), .flt_vaddr(flt_vaddr)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ------------------------------------------------------------
    // Memory model: one-cycle acknowledge after lat wait cycles
    // ------------------------------------------------------------
    logic [31:0] pmem [logic [28:0]];
    int          lat = 0;
    int          wait_cnt = 0;
    int          nrd, nwr;
    logic [28:0] rd_addr [2];
    logic [28:0] wr_addr;
    logic [31:0] wr_data;

    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    mem_ack  = 1'b1;
                    if (mem_we) begin
                        pmem[mem_addr] = mem_wdata;
                        wr_addr = mem_addr;
                        wr_data = mem_wdata;
                        nwr++;
                    end else begin
                        mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 32'h0;
                        if (nrd < 2) rd_addr[nrd] = mem_addr;
                        nrd++;
                    end
                end
            end
        end
    end

    // ------------------------------------------------------------
    // Walk helpers
    // ------------------------------------------------------------
    bit          got_done, got_flt;
    logic [28:0] got_pa;
    logic [1:0]  got_cause;
    logic [31:0] got_fva;

    task automatic start_walk(input logic [31:0] va, input logic [1:0] kind);
        nrd = 0; nwr = 0; got_done = 0; got_flt = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_walk();
        for (int n = 0; n < 80; n++) begin
            if (done) begin got_done = 1; got_pa = done_paddr; break; end
            if (flt)  begin got_flt = 1; got_cause = flt_cause; got_fva = flt_vaddr; break; end
            @(negedge clk);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] kind);
        start_walk(va, kind);
        finish_walk();
    endtask

    function automatic logic [1:0] outcome();
        if (got_done) return 2'd0;
        if (got_flt)  return got_cause;
        return 2'd3;
    endfunction

    // ------------------------------------------------------------
    // Vector table. outc: 0 done, 1 not present, 2 protection
    // ------------------------------------------------------------
    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic [1:0]  outc;
        logic [28:0] pa;
        logic [1:0]  reads;
        logic        wr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{32'h00400ABC, 2'd0, 2'd0, 29'h1ABCDABC, 2'd2, 1'b0},  // R4 load, R-only page
        '{32'h00400123, 2'd1, 2'd2, 29'h0,        2'd2, 1'b0},  // R7 store needs W
        '{32'h00400FFF, 2'd2, 2'd2, 29'h0,        2'd2, 1'b0},  // R7 fetch needs X
        '{32'h00401010, 2'd0, 2'd0, 29'h00345010, 2'd2, 1'b0},  // R4 load of RW page
        '{32'h00402000, 2'd2, 2'd0, 29'h0F0F0000, 2'd2, 1'b0},  // R7 fetch X page
        '{32'h00402004, 2'd0, 2'd2, 29'h0,        2'd2, 1'b0},  // R7 load on X-only
        '{32'h00403777, 2'd0, 2'd1, 29'h0,        2'd2, 1'b0},  // R6 leaf absent
        '{32'h00800000, 2'd0, 2'd1, 29'h0,        2'd1, 1'b0},  // R5 directory absent
        '{32'h00404FFC, 2'd1, 2'd0, 29'h12345FFC, 2'd2, 1'b0},  // R8 store dirty page
        '{32'h00401008, 2'd1, 2'd0, 29'h00345008, 2'd2, 1'b1}   // R8 store clean page
    };

    initial begin
        rst_n = 1'b0; base_we = 1'b0; base_ppn = '0;
        req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        nrd = 0; nwr = 0;

        // Tables for base 0x10
        pmem[29'h10004] = 32'h00020001;
        pmem[29'h20000] = 32'h1ABCD003;
        pmem[29'h20004] = 32'h00345007;
        pmem[29'h20008] = 32'h0F0F0009;
        pmem[29'h20010] = 32'h12345017;
        // Tables for base 0x11
        pmem[29'h11004] = 32'h00021001;
        pmem[29'h21000] = 32'h0AAAA003;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
        chk(mem_req == 1'b0,   "R1 mem_req",   32'(mem_req),   32'd0);
        chk(done == 1'b0 && flt == 1'b0, "R1 done/flt", {30'd0, done, flt}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: base is 0 after reset, so directory read goes to {0, idx, 00}
        walk(32'h00400000, 2'd0);
        chk(rd_addr[0] == 29'h00004, "R1 base zero dir addr", 32'(rd_addr[0]), 32'h4);
        chk(outcome() == 2'd1, "R5 empty directory", 32'(outcome()), 32'd1);

        base_we = 1'b1; base_ppn = 17'h00010;
        @(negedge clk);
        base_we = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [28:0] exp_dir, exp_leaf;
            v = VT[i];
            lat = i % 3;
            exp_dir  = {17'h00010, v.va[31:22], 2'b00};
            exp_leaf = {17'h00020, v.va[21:12], 2'b00};
            walk(v.va, v.kind);
            chk(outcome() == v.outc, $sformatf("R7 vec%0d outcome", i), 32'(outcome()), 32'(v.outc));
            chk(rd_addr[0] == exp_dir, $sformatf("R2 vec%0d dir addr", i), 32'(rd_addr[0]), 32'(exp_dir));
            if (v.reads == 2'd2)
                chk(rd_addr[1] == exp_leaf, $sformatf("R3 vec%0d leaf addr", i), 32'(rd_addr[1]), 32'(exp_leaf));
            chk(nrd == int'(v.reads), $sformatf("R5 vec%0d read count", i), 32'(nrd), 32'(v.reads));
            chk(nwr == int'(v.wr), $sformatf("R8 vec%0d write count", i), 32'(nwr), 32'(v.wr));
            if (v.outc == 2'd0)
                chk(got_pa == v.pa, $sformatf("R4 vec%0d paddr", i), 32'(got_pa), 32'(v.pa));
            else
                chk(got_fva == v.va, $sformatf("R9 vec%0d fault vaddr", i), got_fva, v.va);
        end

        // R8: write-back contents and a repeat store that needs none
        chk(wr_addr == 29'h20004, "R8 write-back addr", 32'(wr_addr), 32'h20004);
        chk(wr_data == 32'h00345017, "R8 write-back data", wr_data, 32'h00345017);
        walk(32'h00401ABC, 2'd1);
        chk(nwr == 0, "R8 second store no write", 32'(nwr), 32'd0);
        chk(got_pa == 29'h00345ABC, "R4 second store paddr", 32'(got_pa), 32'h00345ABC);

        // R7: spare kind code behaves as a load
        walk(32'h00402008, 2'd3);
        chk(outcome() == 2'd2, "R7 kind3 on X-only", 32'(outcome()), 32'd2);
        walk(32'h00400008, 2'd3);
        chk(outcome() == 2'd0 && got_pa == 29'h1ABCD008, "R7 kind3 on R page", 32'(got_pa), 32'h1ABCD008);

        // R10: base write during a walk leaves it on the old tables
        lat = 3;
        start_walk(32'h00400ABC, 2'd0);
        base_we = 1'b1; base_ppn = 17'h00011;
        @(negedge clk);
        base_we = 1'b0;
        finish_walk();
        chk(got_done && got_pa == 29'h1ABCDABC, "R10 walk in flight", 32'(got_pa), 32'h1ABCDABC);
        lat = 0;
        walk(32'h00400ABC, 2'd0);
        chk(got_done && got_pa == 29'h0AAAAABC, "R10 next walk new base", 32'(got_pa), 32'h0AAAAABC);
        chk(rd_addr[0] == 29'h11004, "R10 new dir addr", 32'(rd_addr[0]), 32'h11004);

        // R11: idle after the walk, no memory traffic
        @(negedge clk);
        chk(req_ready && !mem_req, "R11 idle between walks", {30'd0, req_ready, mem_req}, 32'd2);

        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule